// File: doc/BRIEF.md
# SPI Serial EEPROM Word Controller

This block gives a host simple word-level access to a serial EEPROM that speaks a byte-addressed SPI command set. The host presents one request, made of a starting word offset, a word count and a direction flag. Read data comes back as a stream of 16-bit words. Write data is pulled from the host one word at a time, with a one-cycle take strobe for each word. When the request has completed or failed, the block returns a single completion pulse that carries an error flag.

On the wire the block is an SPI mode-0 master. Chip select is active low. Bits go out MSB first, and the serial clock is derived from the system clock by a fixed divider. Before every command the block polls the device status register until the device reports ready. Each write burst is preceded by its own write-enable frame. A burst is cut wherever the next byte address crosses a device page, and the following burst starts again with a fresh poll and write-enable. The device stores each word low byte first, so the block swaps bytes in both directions. After the last write burst the block waits out a fixed write-cycle time before it signals completion.

Top module: `spi_eeprom_ctrl`

## Requirements
- R1: After reset, csN is 1, sck is 0, reqReady is 1 and doneValid is 0.
- R2: A request is rejected when its offset is at least WORD_SIZE, when its count is zero, or when offset plus count exceeds WORD_SIZE. A rejected request produces doneValid with doneErr=1 and never drives csN low. A request that ends exactly on the last word is accepted.
- R3: Before each command the block sends status-read opcode 0x05 and shifts in 8 status bits. It repeats this, with a csN high gap between attempts, while status bit 0 is 1. After RETRY_MAX busy answers it ends the request with doneErr=1 and issues no read or write command.
- R4: A read sends opcode 0x03, then the byte address (offset*2) as its low ADDR_BITS bits, then shifts in 16 bits per word, all within one chip-select frame for the whole request. Each word arrives on rdData with rdValid, equal to {second byte received, first byte received}.
- R5: When ADDR_BITS is 8 and the word offset that starts a command is 128 or more, that read or write opcode has bit 3 (0x08) set, which carries byte-address bit 8.
- R6: Every write burst is preceded by a separate frame carrying only opcode 0x06, after which csN goes high. The burst itself sends opcode 0x02, the byte address and then each host word low byte first. wrReady pulses once per word, and only while csN is low.
- R7: A write burst ends after any word whose following byte address is a multiple of PAGE_BYTES (a power of two). The next burst begins with a new status poll and write-enable, so a write touching P pages uses P write-enable frames and P write commands.
- R8: After a successful write, doneValid rises no earlier than WRITE_WAIT cycles after csN last rose.
- R9: sck is 0 whenever csN is 1. mosi changes only while sck is 0. mosi is 0 while status or read data is being received.
- R10: Each accepted or rejected request yields exactly one single-cycle doneValid. reqReady is 0, and no rdValid occurs, except while the block is idle. csN stays high while the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe, taken when reqReady is 1 |
| reqReady | output | 1 | Block idle and able to take a request |
| reqWrite | input | 1 | 1 = write request, 0 = read request |
| reqOffset | input | OFF_W | Starting word offset |
| reqCount | input | CNT_W | Number of words |
| wrData | input | 16 | Next host word to write |
| wrReady | output | 1 | wrData consumed this cycle |
| rdData | output | 16 | Word read from the device |
| rdValid | output | 1 | rdData valid for one cycle |
| doneValid | output | 1 | Request finished (one cycle) |
| doneErr | output | 1 | Finished request failed or was rejected |
| csN | output | 1 | Device chip select, active low |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |

## Verification
The bench builds the block with WORD_SIZE=256, ADDR_BITS=8, PAGE_BYTES=8, SCK_HALF=2, RETRY_MAX=4, GAP_CYCLES=3 and WRITE_WAIT=50. An eight-byte page lets a six-word write split into two bursts, so the write-enable count and the re-poll after a burst come within reach. With 8 address bits and 256 words, offsets at and above 128 exercise the opcode-folded ninth address bit, and a read that crosses offset 128 within one command does as well. The small retry limit and write time let the status timeout and the write-cycle wait be observed within a few thousand cycles. The device model reports busy for two polls after each write burst, and it can be forced to stay busy.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;

  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_A8    = 8'h08;

  // strobes from control to the serial datapath
  typedef struct packed {
    logic        shiftStart;
    logic [4:0]  shiftBits;
    logic [15:0] txWord;
    logic        csLow;
    logic        csHigh;
  } spiStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_LAUNCH, S_SHIFT, S_GAP, S_WCYCLE, S_FINISH
  } ctlState_t;

  typedef enum logic [2:0] {
    P_POLL_OP, P_POLL_RX, P_WREN, P_CMD, P_ADDR, P_XFER
  } phase_t;

  function automatic logic [15:0] swapBytes(input logic [15:0] w);
    return {w[7:0], w[15:8]};
  endfunction

endpackage

// File: rtl/spi_eeprom_dp.sv
module spi_eeprom_dp
  import spi_eeprom_pkg::*;
#(
  parameter int SCK_HALF = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  spiStrobe_t  strb,
  input  logic        miso,
  output logic        csN,
  output logic        sck,
  output logic        mosi,
  output logic        shDone,
  output logic [15:0] rxWord
);

  localparam int DIV_W = $clog2(SCK_HALF + 1);
  localparam logic [DIV_W-1:0] DIV_RELOAD = DIV_W'(SCK_HALF - 1);

  logic [DIV_W-1:0] divCnt;
  logic             busy;
  logic             highPh;
  logic [4:0]       bitsLeft;
  logic [15:0]      txSh;
  logic [15:0]      rxSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csN      <= 1'b1;
      sck      <= 1'b0;
      busy     <= 1'b0;
      highPh   <= 1'b0;
      divCnt   <= '0;
      bitsLeft <= '0;
      txSh     <= '0;
      rxSh     <= '0;
      shDone   <= 1'b0;
    end else begin
      shDone <= 1'b0;
      if (strb.csHigh)     csN <= 1'b1;
      else if (strb.csLow) csN <= 1'b0;

      if (strb.shiftStart) begin
        busy     <= 1'b1;
        highPh   <= 1'b0;
        sck      <= 1'b0;
        divCnt   <= DIV_RELOAD;
        bitsLeft <= strb.shiftBits;
        txSh     <= strb.txWord << (5'd16 - strb.shiftBits);
      end else if (busy) begin
        if (divCnt != '0) begin
          divCnt <= divCnt - 1'b1;
        end else begin
          divCnt <= DIV_RELOAD;
          if (!highPh) begin
            sck    <= 1'b1;
            highPh <= 1'b1;
          end else begin
            sck      <= 1'b0;
            highPh   <= 1'b0;
            rxSh     <= {rxSh[14:0], miso};
            txSh     <= {txSh[14:0], 1'b0};
            bitsLeft <= bitsLeft - 1'b1;
            if (bitsLeft == 5'd1) begin
              busy   <= 1'b0;
              shDone <= 1'b1;
            end
          end
        end
      end
    end
  end

  assign mosi   = busy & txSh[15];
  assign rxWord = rxSh;

endmodule

// File: rtl/spi_eeprom_ctl.sv
module spi_eeprom_ctl
  import spi_eeprom_pkg::*;
#(
  parameter int WORD_SIZE  = 256,
  parameter int ADDR_BITS  = 8,
  parameter int PAGE_BYTES = 32,
  parameter int RETRY_MAX  = 256,
  parameter int GAP_CYCLES = 8,
  parameter int WRITE_WAIT = 2000000,
  parameter int OFF_W      = 16,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic             reqWrite,
  input  logic [OFF_W-1:0] reqOffset,
  input  logic [CNT_W-1:0] reqCount,
  input  logic [15:0]      wrData,
  output logic             wrReady,
  output logic [15:0]      rdData,
  output logic             rdValid,
  output logic             doneValid,
  output logic             doneErr,
  input  logic             shDone,
  input  logic [15:0]      rxWord,
  output spiStrobe_t       strb
);

  localparam int TMR_MAX = (WRITE_WAIT > GAP_CYCLES) ? WRITE_WAIT : GAP_CYCLES;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int RTY_W   = $clog2(RETRY_MAX + 1);
  localparam int PG_W    = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1;

  ctlState_t        state;
  ctlState_t        gapNext;
  phase_t           ph;
  logic             isWrite;
  logic             errFlag;
  logic [OFF_W-1:0] curOff;
  logic [CNT_W-1:0] remain;
  logic [RTY_W-1:0] retry;
  logic [TMR_W-1:0] tmr;

  logic             badReq;
  logic             lastWord;
  logic             pageEnd;
  logic             useA8;
  logic [OFF_W-1:0] nextOff;
  logic [OFF_W:0]   nextByte;
  logic [OFF_W:0]   curByte;
  logic [7:0]       cmdOp;

  always_comb begin
    badReq = (int'(reqOffset) >= WORD_SIZE) || (reqCount == '0) ||
             (int'(reqCount) > (WORD_SIZE - int'(reqOffset)));
    nextOff  = curOff + 1'b1;
    nextByte = {nextOff, 1'b0};
    curByte  = {curOff, 1'b0};
    lastWord = (remain == CNT_W'(1));
    pageEnd  = isWrite && (nextByte[PG_W-1:0] == '0);
    useA8    = (ADDR_BITS == 8) && (int'(curOff) >= 128);
    cmdOp    = (isWrite ? OP_WRITE : OP_READ) | (useA8 ? OP_A8 : 8'h00);
  end

  assign reqReady = (state == S_IDLE);

  // strobes toward the datapath
  always_comb begin
    strb    = '0;
    wrReady = 1'b0;
    if (state == S_LAUNCH) begin
      strb.shiftStart = 1'b1;
      strb.csLow      = 1'b1;
      unique case (ph)
        P_POLL_OP: begin strb.shiftBits = 5'd8;  strb.txWord = {8'h00, OP_RDSR}; end
        P_POLL_RX: begin strb.shiftBits = 5'd8;  strb.txWord = 16'h0000; end
        P_WREN:    begin strb.shiftBits = 5'd8;  strb.txWord = {8'h00, OP_WREN}; end
        P_CMD:     begin strb.shiftBits = 5'd8;  strb.txWord = {8'h00, cmdOp}; end
        P_ADDR:    begin strb.shiftBits = 5'(ADDR_BITS); strb.txWord = 16'(curByte); end
        default: begin
          strb.shiftBits = 5'd16;
          strb.txWord    = isWrite ? swapBytes(wrData) : 16'h0000;
          wrReady        = isWrite;
        end
      endcase
    end else if (state == S_SHIFT && shDone) begin
      strb.csHigh = (ph == P_POLL_RX) || (ph == P_WREN) ||
                    ((ph == P_XFER) && (lastWord || pageEnd));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      gapNext   <= S_IDLE;
      ph        <= P_POLL_OP;
      isWrite   <= 1'b0;
      errFlag   <= 1'b0;
      curOff    <= '0;
      remain    <= '0;
      retry     <= '0;
      tmr       <= '0;
      rdData    <= '0;
      rdValid   <= 1'b0;
      doneValid <= 1'b0;
      doneErr   <= 1'b0;
    end else begin
      rdValid   <= 1'b0;
      doneValid <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (reqValid) begin
            isWrite <= reqWrite;
            curOff  <= reqOffset;
            remain  <= reqCount;
            retry   <= '0;
            ph      <= P_POLL_OP;
            errFlag <= badReq;
            state   <= badReq ? S_FINISH : S_LAUNCH;
          end
        end
        S_LAUNCH: state <= S_SHIFT;
        S_SHIFT: begin
          if (shDone) begin
            unique case (ph)
              P_POLL_OP: begin ph <= P_POLL_RX; state <= S_LAUNCH; end
              P_POLL_RX: begin
                state <= S_GAP;
                tmr   <= TMR_W'(GAP_CYCLES - 1);
                if (!rxWord[0]) begin
                  retry   <= '0;
                  ph      <= isWrite ? P_WREN : P_CMD;
                  gapNext <= S_LAUNCH;
                end else if (retry == RTY_W'(RETRY_MAX - 1)) begin
                  errFlag <= 1'b1;
                  gapNext <= S_FINISH;
                end else begin
                  retry   <= retry + 1'b1;
                  ph      <= P_POLL_OP;
                  gapNext <= S_LAUNCH;
                end
              end
              P_WREN: begin
                ph      <= P_CMD;
                state   <= S_GAP;
                gapNext <= S_LAUNCH;
                tmr     <= TMR_W'(GAP_CYCLES - 1);
              end
              P_CMD:  begin ph <= P_ADDR; state <= S_LAUNCH; end
              P_ADDR: begin ph <= P_XFER; state <= S_LAUNCH; end
              default: begin
                curOff <= nextOff;
                remain <= remain - 1'b1;
                if (!isWrite) begin
                  rdValid <= 1'b1;
                  rdData  <= swapBytes(rxWord);
                end
                if (lastWord) begin
                  state   <= S_GAP;
                  gapNext <= isWrite ? S_WCYCLE : S_FINISH;
                  tmr     <= TMR_W'(GAP_CYCLES - 1);
                end else if (pageEnd) begin
                  ph      <= P_POLL_OP;
                  state   <= S_GAP;
                  gapNext <= S_LAUNCH;
                  tmr     <= TMR_W'(GAP_CYCLES - 1);
                end else begin
                  state <= S_LAUNCH;
                end
              end
            endcase
          end
        end
        S_GAP: begin
          if (tmr == '0) begin
            state <= gapNext;
            if (gapNext == S_WCYCLE) tmr <= TMR_W'(WRITE_WAIT - 1);
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        S_WCYCLE: begin
          if (tmr == '0) state <= S_FINISH;
          else           tmr <= tmr - 1'b1;
        end
        default: begin
          doneValid <= 1'b1;
          doneErr   <= errFlag;
          state     <= S_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl
  import spi_eeprom_pkg::*;
#(
  parameter int WORD_SIZE  = 256,
  parameter int ADDR_BITS  = 8,
  parameter int PAGE_BYTES = 32,
  parameter int SCK_HALF   = 4,
  parameter int RETRY_MAX  = 256,
  parameter int GAP_CYCLES = 8,
  parameter int WRITE_WAIT = 2000000,
  parameter int OFF_W      = 16,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic             reqWrite,
  input  logic [OFF_W-1:0] reqOffset,
  input  logic [CNT_W-1:0] reqCount,
  input  logic [15:0]      wrData,
  output logic             wrReady,
  output logic [15:0]      rdData,
  output logic             rdValid,
  output logic             doneValid,
  output logic             doneErr,
  output logic             csN,
  output logic             sck,
  output logic             mosi,
  input  logic             miso
);

  spiStrobe_t  strb;
  logic        shDone;
  logic [15:0] rxWord;

  spi_eeprom_ctl #(
    .WORD_SIZE (WORD_SIZE),
    .ADDR_BITS (ADDR_BITS),
    .PAGE_BYTES(PAGE_BYTES),
    .RETRY_MAX (RETRY_MAX),
    .GAP_CYCLES(GAP_CYCLES),
    .WRITE_WAIT(WRITE_WAIT),
    .OFF_W     (OFF_W),
    .CNT_W     (CNT_W)
  ) ctl_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqOffset(reqOffset), .reqCount(reqCount),
    .wrData(wrData), .wrReady(wrReady),
    .rdData(rdData), .rdValid(rdValid),
    .doneValid(doneValid), .doneErr(doneErr),
    .shDone(shDone), .rxWord(rxWord), .strb(strb)
  );

  spi_eeprom_dp #(.SCK_HALF(SCK_HALF)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .miso(miso),
    .csN(csN), .sck(sck), .mosi(mosi),
    .shDone(shDone), .rxWord(rxWord)
  );

endmodule

// File: rtl/spi_eeprom_ctrl_chk.sv
module spi_eeprom_ctrl_chk #(
  parameter int WRITE_WAIT = 2000000
) (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqReady,
  input logic reqWrite,
  input logic wrReady,
  input logic rdValid,
  input logic doneValid,
  input logic doneErr,
  input logic csN,
  input logic sck,
  input logic mosi
);

  logic        wasWrite;
  logic [31:0] csHighCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wasWrite  <= 1'b0;
      csHighCnt <= '0;
    end else begin
      if (reqValid && reqReady) wasWrite <= reqWrite;
      if (!csN)                        csHighCnt <= '0;
      else if (csHighCnt != 32'hFFFF_FFFF) csHighCnt <= csHighCnt + 1'b1;
    end
  end

  a_r9_sck_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sck);

  a_r9_mosi_steady_high: assert property (@(posedge clk) disable iff (!rstN)
    (sck && $past(sck)) |-> $stable(mosi));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  a_r10_idle_bus_quiet: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> csN);

  a_r10_rd_not_idle: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !reqReady);

  a_r6_wr_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    wrReady |-> !csN);

  a_r8_write_wait: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && !doneErr && wasWrite) |-> (csHighCnt >= 32'(WRITE_WAIT)));

endmodule

bind spi_eeprom_ctrl spi_eeprom_ctrl_chk #(.WRITE_WAIT(WRITE_WAIT)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqWrite(reqWrite), .wrReady(wrReady), .rdValid(rdValid),
  .doneValid(doneValid), .doneErr(doneErr), .csN(csN), .sck(sck), .mosi(mosi)
);

// File: tb/spi_eeprom_ctrl_tb_top.sv
`timescale 1ns/1ps
module spi_eeprom_ctrl_tb_top;

  localparam int WORDS = 256;
  localparam int RETRIES = 4;
  localparam int WWAIT = 50;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [15:0] reqOffset = '0;
  logic [15:0] reqCount = '0;
  logic [15:0] wrData;
  logic reqReady, wrReady, rdValid, doneValid, doneErr, csN, sck, mosi;
  logic [15:0] rdData;
  logic miso = 1'b0;

  always #2.5 clk = ~clk;

  spi_eeprom_ctrl #(
    .WORD_SIZE(WORDS), .ADDR_BITS(8), .PAGE_BYTES(8), .SCK_HALF(2),
    .RETRY_MAX(RETRIES), .GAP_CYCLES(3), .WRITE_WAIT(WWAIT),
    .OFF_W(16), .CNT_W(16)
  ) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqOffset(reqOffset), .reqCount(reqCount),
    .wrData(wrData), .wrReady(wrReady), .rdData(rdData), .rdValid(rdValid),
    .doneValid(doneValid), .doneErr(doneErr), .csN(csN), .sck(sck),
    .mosi(mosi), .miso(miso)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  logic [7:0] mem [0:511];
  int bitCnt = 0;
  logic [7:0] inSh = 0, opc = 0, outSh = 0;
  int addr = 0;
  bit addrHi = 0, wel = 0, wrote = 0, forceBusy = 0;
  int busyPolls = 0;
  int nRdsr = 0, nWren = 0, nWrite = 0, nRead = 0, nCsFall = 0, protoErr = 0;

  function automatic bit isRd(input logic [7:0] o);
    return (o == 8'h03) || (o == 8'h0B);
  endfunction
  function automatic bit isWr(input logic [7:0] o);
    return (o == 8'h02) || (o == 8'h0A);
  endfunction

  initial for (int i = 0; i < 512; i++) mem[i] = 8'((i * 37 + 5) & 255);

  always @(negedge csN) begin bitCnt = 0; wrote = 0; nCsFall++; end
  always @(posedge csN) if (wrote) begin busyPolls = 2; wel = 0; end

  always @(posedge sck) if (!csN) begin
    if (bitCnt > 8 && opc == 8'h05 && mosi) protoErr++;
    if (bitCnt >= 16 && isRd(opc) && mosi) protoErr++;
    inSh = {inSh[6:0], mosi};
    bitCnt++;
    if (bitCnt == 8) begin
      opc = inSh;
      addrHi = inSh[3];
      if (inSh == 8'h05) begin
        nRdsr++;
        outSh = {7'b0, (forceBusy || busyPolls > 0)};
        if (busyPolls > 0) busyPolls--;
      end else if (inSh == 8'h06) begin
        nWren++; wel = 1;
      end else if (isRd(inSh)) nRead++;
      else if (isWr(inSh)) begin
        nWrite++;
        if (!wel) protoErr++;
      end else protoErr++;
    end else if (bitCnt == 16 && (isRd(opc) || isWr(opc))) begin
      addr = {addrHi, inSh};
      if (isRd(opc)) begin outSh = mem[addr]; addr = (addr + 1) % 512; end
    end else if (bitCnt > 16 && bitCnt % 8 == 0) begin
      if (isRd(opc)) begin outSh = mem[addr]; addr = (addr + 1) % 512; end
      if (isWr(opc)) begin mem[addr] = inSh; addr = (addr + 1) % 512; wrote = 1; end
    end
  end

  always @(negedge sck) if (!csN) begin
    miso = outSh[7];
    outSh = {outSh[6:0], 1'b0};
  end

  // ---------------- host side ----------------
  logic [15:0] wrBuf [0:15];
  int wrIdx = 0;
  assign wrData = wrBuf[wrIdx[3:0]];
  always @(posedge clk) if (wrReady) wrIdx <= wrIdx + 1;

  logic [15:0] rdBuf [0:15];
  int rdN = 0, doneN = 0, cyc = 0, csRiseCyc = 0, doneCyc = 0, sckErr = 0;
  bit lastErr = 0;
  logic prevCs = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (rdValid) begin rdBuf[rdN[3:0]] = rdData; rdN++; end
    if (doneValid) begin doneN++; lastErr = doneErr; doneCyc = cyc; end
    if (csN && !prevCs) csRiseCyc = cyc;
    if (csN && sck) sckErr++;
    prevCs = csN;
  end

  function automatic logic [15:0] memWord(input int off);
    return {mem[(2 * off + 1) % 512], mem[(2 * off) % 512]};
  endfunction

  task automatic runReq(input bit wr, input int off, input int cnt, input string req);
    int d0;
    d0 = doneN;
    rdN = 0;
    wrIdx = 0;
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqOffset = 16'(off); reqCount = 16'(cnt);
    @(negedge clk);
    reqValid = 0;
    for (int i = 0; i < 40000 && doneN == d0; i++) @(negedge clk);
    chk(doneN == d0 + 1, req, doneN - d0, 1);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(csN == 1, "R1 csN", csN, 1);
    chk(sck == 0, "R1 sck", sck, 0);
    chk(reqReady == 1, "R1 reqReady", reqReady, 1);
    chk(doneValid == 0, "R1 doneValid", doneValid, 0);
  endtask

  task automatic t_read_single();
    int r0 = nRead;
    runReq(0, 3, 1, "R10 done read1");
    chk(lastErr == 0, "R4 err", lastErr, 0);
    chk(rdN == 1, "R4 count", rdN, 1);
    chk(rdBuf[0] == memWord(3), "R4 word", rdBuf[0], memWord(3));
    chk(nRead - r0 == 1, "R4 cmds", nRead - r0, 1);
  endtask

  task automatic t_read_multi();
    int r0 = nRead, s0 = nRdsr;
    runReq(0, 10, 5, "R10 done read5");
    chk(rdN == 5, "R4 multi count", rdN, 5);
    for (int k = 0; k < 5; k++)
      chk(rdBuf[k] == memWord(10 + k), "R4 multi word", rdBuf[k], memWord(10 + k));
    chk(nRead - r0 == 1, "R4 one command", nRead - r0, 1);
    chk(nRdsr - s0 == 1, "R3 poll before read", nRdsr - s0, 1);
  endtask

  task automatic t_read_a8();
    runReq(0, 200, 2, "R10 done a8");
    chk(rdBuf[0] == memWord(200), "R5 a8 w0", rdBuf[0], memWord(200));
    chk(rdBuf[1] == memWord(201), "R5 a8 w1", rdBuf[1], memWord(201));
    runReq(0, 127, 2, "R10 done cross");
    chk(rdBuf[0] == memWord(127), "R5 cross w0", rdBuf[0], memWord(127));
    chk(rdBuf[1] == memWord(128), "R5 cross w1", rdBuf[1], memWord(128));
  endtask

  task automatic t_write_pages();
    int e0 = nWren, w0 = nWrite, s0 = nRdsr;
    for (int k = 0; k < 6; k++) wrBuf[k] = 16'(16'hA100 + k * 16'h0111);
    runReq(1, 2, 6, "R10 done write");
    chk(lastErr == 0, "R6 err", lastErr, 0);
    chk(nWren - e0 == 2, "R7 wren frames", nWren - e0, 2);
    chk(nWrite - w0 == 2, "R7 write cmds", nWrite - w0, 2);
    chk(nRdsr - s0 == 4, "R3 busy re-poll", nRdsr - s0, 4);
    chk(protoErr == 0, "R6 wren before write", protoErr, 0);
    for (int k = 0; k < 6; k++) begin
      chk(mem[2 * (2 + k)] == wrBuf[k][7:0], "R6 low byte first", mem[2 * (2 + k)], wrBuf[k][7:0]);
      chk(mem[2 * (2 + k) + 1] == wrBuf[k][15:8], "R6 high byte", mem[2 * (2 + k) + 1], wrBuf[k][15:8]);
    end
    chk(doneCyc - csRiseCyc >= WWAIT, "R8 write wait", doneCyc - csRiseCyc, WWAIT);
    runReq(0, 2, 6, "R10 done readback");
    for (int k = 0; k < 6; k++)
      chk(rdBuf[k] == wrBuf[k], "R6 readback", rdBuf[k], wrBuf[k]);
  endtask

  task automatic t_write_a8();
    wrBuf[0] = 16'hBEEF;
    runReq(1, 130, 1, "R10 done a8 write");
    chk(mem[260] == 8'hEF, "R5 a8 write lo", mem[260], 8'hEF);
    chk(mem[261] == 8'hBE, "R5 a8 write hi", mem[261], 8'hBE);
  endtask

  task automatic t_retry_limit();
    int s0 = nRdsr, r0 = nRead;
    forceBusy = 1;
    runReq(0, 0, 1, "R10 done retry");
    forceBusy = 0;
    chk(lastErr == 1, "R3 timeout err", lastErr, 1);
    chk(nRdsr - s0 == RETRIES, "R3 attempts", nRdsr - s0, RETRIES);
    chk(nRead - r0 == 0, "R3 no command", nRead - r0, 0);
    chk(rdN == 0, "R3 no data", rdN, 0);
  endtask

  task automatic t_bounds();
    int c0;
    c0 = nCsFall;
    runReq(0, 256, 1, "R10 done oob");
    chk(lastErr == 1, "R2 offset", lastErr, 1);
    runReq(0, 0, 0, "R10 done zero");
    chk(lastErr == 1, "R2 zero count", lastErr, 1);
    runReq(1, 250, 7, "R10 done past end");
    chk(lastErr == 1, "R2 past end", lastErr, 1);
    chk(nCsFall - c0 == 0, "R2 bus untouched", nCsFall - c0, 0);
    runReq(0, 250, 6, "R10 done last words");
    chk(lastErr == 0, "R2 exact end ok", lastErr, 0);
    chk(rdBuf[5] == memWord(255), "R2 last word", rdBuf[5], memWord(255));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rstN = 1;
    repeat (3) @(negedge clk);
    t_read_single();
    t_read_multi();
    t_read_a8();
    t_write_pages();
    t_write_a8();
    t_retry_limit();
    t_bounds();
    chk(sckErr == 0, "R9 sck idle low", sckErr, 0);
    chk(protoErr == 0, "R9 mosi low on receive", protoErr, 0);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule